// File: doc/BRIEF.md
# Instruction Fetch Queue with Half-Word Realignment

This block sits between an instruction fetcher and a decode stage. The fetcher delivers aligned 32-bit memory words. The queue stores each word together with the address it was fetched from and an error flag. A decode stage reads whole instructions from it, one per handshake. The queue tracks the current instruction address at half-word resolution, so its output can be a 16-bit compressed instruction in either half of a word, or a 32-bit instruction. A 32-bit instruction may start in the upper half of one word and end in the lower half of the next, and the queue joins the two halves.

Both data sides use valid/ready. On the input side, a word moves when `in_valid_i` and `in_ready_o` are both high. `in_ready_o` depends only on the fill level and on `clear_i`, so the fetcher can also pace its requests from `free_o`. On the output side, an instruction is consumed when `out_valid_o` and `out_ready_i` are both high. While the decode stage holds `out_ready_i` low, the presented instruction and its address stay unchanged. When the queue is empty, an accepted word is routed to the output in the same cycle.

A flush through `clear_i` drops all stored words in one cycle. The following word is taken to belong to the restart address supplied with the flush. That address may point at either half of a word.

Top module: `ifq_realign`

## Requirements
- R1: After reset the queue is empty: `out_valid_o` is 0 while no word is offered, `free_o` equals DEPTH (default 3), and `in_ready_o` is 1.
- R2: When no word is stored, a word accepted in a cycle is presented on the output in that same cycle, provided it completes an instruction.
- R3: `free_o` equals DEPTH minus the number of stored words. `in_ready_o` is 0 when all DEPTH entries are occupied or while `clear_i` is high.
- R4: At a word-aligned address (out_pc bit 1 = 0), the instruction is compressed when word bits [1:0] are not 2'b11. It is then output as the low half, zero-extended to 32 bits. Otherwise the whole word is output.
- R5: At a half-word address (out_pc bit 1 = 1) whose upper half has bits [17:16] not equal to 2'b11, the output is that upper half, zero-extended.
- R6: At a half-word address whose upper half is not compressed, the output is {next word [15:0], current word [31:16]}. It is flagged valid only once the next word is stored or being accepted.
- R7: `out_pc_o` bit 0 is always 0. After each consumed instruction, the next presented address is 2 higher for a compressed instruction and 4 higher for a full one.
- R8: While `out_valid_o` is high and `out_ready_i` is low, the instruction, its address and the valid flag hold in the next cycle, unless a clear occurs.
- R9: A cycle with `clear_i` high forces `out_valid_o` low, accepts no word, and leaves the queue empty in the next cycle. The next instruction address is then the restart address, whose bits [31:2] tag the next accepted word.
- R10: `out_err_o` is the error flag of the word holding the instruction. For an instruction that spans two words, it is the OR of both words' flags.
- R11: `out_compressed_o` is 1 exactly when the presented instruction is a 16-bit one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Flush all stored words and restart |
| restart_pc_i | input | 31 | Restart address bits [31:1], used with clear_i |
| in_valid_i | input | 1 | Fetched word offered |
| in_ready_o | output | 1 | Queue accepts the offered word |
| in_word_i | input | 32 | Fetched aligned memory word |
| in_err_i | input | 1 | Fetch error for this word |
| free_o | output | $clog2(DEPTH+1) | Number of unused entries |
| out_valid_o | output | 1 | A complete instruction is presented |
| out_ready_i | input | 1 | Decode stage takes the instruction |
| out_instr_o | output | 32 | Instruction; 16-bit ones zero-extended |
| out_pc_o | output | 32 | Address of the presented instruction |
| out_err_o | output | 1 | Fetch error on any word of the instruction |
| out_compressed_o | output | 1 | Presented instruction is 16 bits |

## Verification
The assertions assume a fetcher that never pushes into a full queue. That assumption holds because a word moves only with `in_ready_o` high. They also assume that fetched words arrive in address order after each restart, so the stored address tags step by 4 and the address-step property can rely on that. The stimulus drives random words whose halves are randomly compressed or not, random input and output stalls, and occasional flushes to random restart addresses. Every word presented is the next sequential word, so the order assumption is never broken.

// File: rtl/ifq_pkg.sv
package ifq_pkg;
  localparam int XLEN = 32;
  localparam int HALF = XLEN / 2;

  typedef struct packed {
    logic [XLEN-1:0] data;
    logic [XLEN-3:0] wpc;   // word address of the stored word
    logic            err;
  } ifq_entry_t;

  function automatic logic is_short(input logic [1:0] lo);
    return lo != 2'b11;
  endfunction
endpackage

// File: rtl/ifq_store.sv
module ifq_store
  import ifq_pkg::*;
#(
  parameter int DEPTH = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clear_i,
  input  logic                       push_i,
  input  ifq_entry_t                 push_ent_i,
  input  logic                       pop_i,
  output logic [$clog2(DEPTH+1)-1:0] count_o,
  output ifq_entry_t                 head_o,
  output logic [HALF-1:0]            next_lo_o,
  output logic                       next_err_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH+1);

  ifq_entry_t       mem [DEPTH];
  logic [PTR_W-1:0] head_q, tail_q, nxt;
  logic [CNT_W-1:0] count_q;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push_i && !clear_i && tail_q == PTR_W'(g)) mem[g] <= push_ent_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else if (clear_i) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else begin
      if (push_i) tail_q <= bump(tail_q);
      if (pop_i)  head_q <= bump(head_q);
      count_q <= count_q + CNT_W'(push_i) - CNT_W'(pop_i);
    end
  end

  assign nxt        = bump(head_q);
  assign count_o    = count_q;
  assign head_o     = mem[head_q];
  assign next_lo_o  = mem[nxt].data[HALF-1:0];
  assign next_err_o = mem[nxt].err;

  // R3: the fetcher never writes past the last free slot
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |-> count_q < CNT_W'(DEPTH));
  // R3: nothing is removed from an empty store
  p_no_underflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |-> count_q != '0);
  // R9: one flush cycle empties every entry
  p_clear_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> count_q == '0);
endmodule

// File: rtl/ifq_align.sv
module ifq_align
  import ifq_pkg::*;
(
  input  logic            half_i,
  input  logic [XLEN-1:0] w0_data_i,
  input  logic            w0_err_i,
  input  logic            w0_vld_i,
  input  logic [HALF-1:0] w1_lo_i,
  input  logic            w1_err_i,
  input  logic            w1_vld_i,
  output logic            vld_o,
  output logic [XLEN-1:0] instr_o,
  output logic            err_o,
  output logic            short_o,
  output logic            drop_word_o
);
  logic [HALF-1:0] lo_h, hi_h;

  always_comb begin
    lo_h = w0_data_i[HALF-1:0];
    hi_h = w0_data_i[XLEN-1:HALF];
    if (!half_i) begin
      short_o = is_short(lo_h[1:0]);
      instr_o = short_o ? {{HALF{1'b0}}, lo_h} : w0_data_i;
      vld_o   = w0_vld_i;
      err_o   = w0_err_i;
    end else begin
      short_o = is_short(hi_h[1:0]);
      instr_o = short_o ? {{HALF{1'b0}}, hi_h} : {w1_lo_i, hi_h};
      vld_o   = short_o ? w0_vld_i : (w0_vld_i && w1_vld_i);
      err_o   = short_o ? w0_err_i : (w0_err_i | w1_err_i);
    end
    // the head word is used up unless a short instruction sits in its low half
    drop_word_o = half_i || !short_o;
  end
endmodule

// File: rtl/ifq_realign.sv
module ifq_realign
  import ifq_pkg::*;
#(
  parameter int              DEPTH   = 3,
  parameter logic [XLEN-1:0] BOOT_PC = '0
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clear_i,
  input  logic [XLEN-1:1]            restart_pc_i,
  input  logic                       in_valid_i,
  output logic                       in_ready_o,
  input  logic [XLEN-1:0]            in_word_i,
  input  logic                       in_err_i,
  output logic [$clog2(DEPTH+1)-1:0] free_o,
  output logic                       out_valid_o,
  input  logic                       out_ready_i,
  output logic [XLEN-1:0]            out_instr_o,
  output logic [XLEN-1:0]            out_pc_o,
  output logic                       out_err_o,
  output logic                       out_compressed_o
);
  localparam int CNT_W = $clog2(DEPTH+1);

  logic [CNT_W-1:0] count;
  ifq_entry_t       head_e, new_e, w0;
  logic [HALF-1:0]  next_lo, w1_lo;
  logic             next_err, w1_err;
  logic             have0, v0, v1, accept, fire, drop_word, pop_word, push, a_vld;
  logic             half_q;
  logic [XLEN-3:0]  wr_wpc_q;

  assign in_ready_o = !clear_i && (count < CNT_W'(DEPTH));
  assign accept     = in_valid_i && in_ready_o;
  assign new_e      = '{data: in_word_i, wpc: wr_wpc_q, err: in_err_i};

  // view of the first two words: storage first, then the word being accepted
  assign have0  = count != '0;
  assign w0     = have0 ? head_e : new_e;
  assign v0     = have0 || accept;
  assign w1_lo  = (count > CNT_W'(1)) ? next_lo  : in_word_i[HALF-1:0];
  assign w1_err = (count > CNT_W'(1)) ? next_err : in_err_i;
  assign v1     = (count > CNT_W'(1)) || (count == CNT_W'(1) && accept);

  ifq_align u_align (
    .half_i      (half_q),
    .w0_data_i   (w0.data),
    .w0_err_i    (w0.err),
    .w0_vld_i    (v0),
    .w1_lo_i     (w1_lo),
    .w1_err_i    (w1_err),
    .w1_vld_i    (v1),
    .vld_o       (a_vld),
    .instr_o     (out_instr_o),
    .err_o       (out_err_o),
    .short_o     (out_compressed_o),
    .drop_word_o (drop_word)
  );

  assign out_valid_o = a_vld && !clear_i;
  assign out_pc_o    = {w0.wpc, half_q, 1'b0};
  assign fire        = out_valid_o && out_ready_i;
  assign pop_word    = fire && drop_word;
  // a word consumed straight from the input never enters storage
  assign push        = accept && !(pop_word && !have0);
  assign free_o      = CNT_W'(DEPTH) - count;

  ifq_store #(.DEPTH(DEPTH)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear_i    (clear_i),
    .push_i     (push),
    .push_ent_i (new_e),
    .pop_i      (pop_word && have0),
    .count_o    (count),
    .head_o     (head_e),
    .next_lo_o  (next_lo),
    .next_err_o (next_err)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q   <= BOOT_PC[1];
      wr_wpc_q <= BOOT_PC[XLEN-1:2];
    end else if (clear_i) begin
      half_q   <= restart_pc_i[1];
      wr_wpc_q <= restart_pc_i[XLEN-1:2];
    end else begin
      if (fire && out_compressed_o) half_q <= !half_q;
      if (accept) wr_wpc_q <= wr_wpc_q + 1'b1;
    end
  end

  // R8: a stalled instruction stays put
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n || clear_i)
    out_valid_o && !out_ready_i |=>
      out_valid_o && $stable(out_instr_o) && $stable(out_pc_o) && $stable(out_err_o));
  // R7: the address advances by the size of the instruction just taken
  p_pc_step_r7: assert property (@(posedge clk) disable iff (!rst_n || clear_i)
    fire |=> !out_valid_o ||
      out_pc_o == $past(out_pc_o) + ($past(out_compressed_o) ? XLEN'(2) : XLEN'(4)));
  // R9: full capacity is reported right after a flush
  p_free_after_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> free_o == CNT_W'(DEPTH));
endmodule

// File: tb/ifq_realign_bench.sv
module ifq_realign_bench;
  localparam int DEPTH = 3;
  localparam int CW    = $clog2(DEPTH+1);

  logic          clk = 1'b0;
  logic          rst_n, clear_i, in_valid_i, in_err_i, out_ready_i;
  logic [31:1]   restart_pc_i;
  logic [31:0]   in_word_i;
  logic          in_ready_o, out_valid_o, out_err_o, out_compressed_o;
  logic [CW-1:0] free_o;
  logic [31:0]   out_instr_o, out_pc_o;

  always #4 clk = ~clk;

  ifq_realign #(.DEPTH(DEPTH)) u_ifq_realign (
    .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .restart_pc_i(restart_pc_i),
    .in_valid_i(in_valid_i), .in_ready_o(in_ready_o), .in_word_i(in_word_i),
    .in_err_i(in_err_i), .free_o(free_o), .out_valid_o(out_valid_o),
    .out_ready_i(out_ready_i), .out_instr_o(out_instr_o), .out_pc_o(out_pc_o),
    .out_err_o(out_err_o), .out_compressed_o(out_compressed_o)
  );

  int          checks = 0, errors = 0;
  bit          done = 1'b0;
  logic [32:0] wq[$];          // {err, word}
  logic [31:0] base;           // address of the oldest word (or of the next one)
  logic        half;
  bit          p_stall = 1'b0;
  logic [31:0] p_instr, p_pc;
  logic [31:0] l_instr, l_pc;
  logic        l_valid, l_err, l_comp;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] gen_word();
    logic [31:0] w = $urandom;
    if ($urandom % 2 == 0) w[1:0]   = 2'b11;
    if ($urandom % 2 == 0) w[17:16] = 2'b11;
    return w;
  endfunction

  task automatic step(input bit clr, input logic [31:0] rpc, input bit iv,
                      input logic [31:0] iw, input bit ie, input bit ordy);
    int n;
    bit rdy, acc, v0, v1, ev, comp, ee;
    logic [32:0] w0, w1;
    logic [31:0] ei;
    string vt, dt;
    @(negedge clk);
    clear_i = clr; restart_pc_i = rpc[31:1]; in_valid_i = iv;
    in_word_i = iw; in_err_i = ie; out_ready_i = ordy;
    #2;
    n   = wq.size();
    rdy = !clr && n < DEPTH;
    acc = iv && rdy;
    w0  = (n > 0) ? wq[0] : {ie, iw};
    w1  = (n > 1) ? wq[1] : {ie, iw};
    v0  = n > 0 || acc;
    v1  = n > 1 || (n == 1 && acc);
    if (!half) begin
      comp = w0[1:0] != 2'b11;
      ei   = comp ? {16'h0, w0[15:0]} : w0[31:0];
      ev   = v0; ee = w0[32]; dt = "R4";
    end else begin
      comp = w0[17:16] != 2'b11;
      ei   = comp ? {16'h0, w0[31:16]} : {w1[15:0], w0[31:16]};
      ev   = comp ? v0 : (v0 && v1);
      ee   = comp ? w0[32] : (w0[32] | w1[32]);
      dt   = comp ? "R5" : "R6";
    end
    ev = ev && !clr;
    vt = clr ? "R9" : ((n == 0) ? "R2" : "R6");
    chk("R3", "in_ready", {31'h0, in_ready_o}, {31'h0, rdy});
    chk("R3", "free", 32'(free_o), 32'(DEPTH - n));
    chk(vt, "valid", {31'h0, out_valid_o}, {31'h0, ev});
    if (ev) begin
      chk(dt, "instr", out_instr_o, ei);
      chk("R7", "pc", out_pc_o, {base[31:2], half, 1'b0});
      chk("R10", "err", {31'h0, out_err_o}, {31'h0, ee});
      chk("R11", "compressed", {31'h0, out_compressed_o}, {31'h0, comp});
    end
    if (p_stall && !clr) begin
      chk("R8", "held instr", out_instr_o, p_instr);
      chk("R8", "held pc", out_pc_o, p_pc);
    end
    l_instr = out_instr_o; l_pc = out_pc_o; l_valid = out_valid_o;
    l_err = out_err_o; l_comp = out_compressed_o;
    p_stall = ev && !ordy && !clr; p_instr = out_instr_o; p_pc = out_pc_o;
    if (clr) begin
      wq.delete();
      base = {rpc[31:2], 2'b00};
      half = rpc[1];
    end else begin
      if (acc) wq.push_back({ie, iw});
      if (ev && ordy) begin
        if (half || !comp) begin
          void'(wq.pop_front());
          base = base + 32'd4;
        end
        if (comp) half = !half;
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog act=running exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1f0c_5a11));
    rst_n = 1'b0; clear_i = 1'b0; restart_pc_i = '0; in_valid_i = 1'b0;
    in_word_i = '0; in_err_i = 1'b0; out_ready_i = 1'b0;
    base = 32'h0; half = 1'b0;
    repeat (3) @(negedge clk);
    #2;
    chk("R1", "valid after reset", {31'h0, out_valid_o}, 32'h0);
    chk("R1", "free after reset", 32'(free_o), 32'(DEPTH));
    chk("R1", "ready after reset", {31'h0, in_ready_o}, 32'h1);
    rst_n = 1'b1;

    // directed: restart mid-word (bit 0 set and ignored), spanning instruction
    step(1'b1, 32'h0000_0103, 1'b0, 32'h0, 1'b0, 1'b1);
    step(1'b0, 32'h0, 1'b1, 32'h1237_0001, 1'b0, 1'b1);
    chk("R6", "span waits for second word", {31'h0, l_valid}, 32'h0);
    step(1'b0, 32'h0, 1'b1, 32'hABCD_5678, 1'b1, 1'b1);
    chk("R6", "span instr", l_instr, 32'h5678_1237);
    chk("R9", "restart pc", l_pc, 32'h0000_0102);
    chk("R10", "span err", {31'h0, l_err}, 32'h1);
    step(1'b0, 32'h0, 1'b0, 32'h0, 1'b0, 1'b1);
    chk("R5", "upper half short", l_instr, 32'h0000_ABCD);
    chk("R7", "pc after span", l_pc, 32'h0000_0106);
    chk("R11", "short flag", {31'h0, l_comp}, 32'h1);
    // fill with the decode stage stalled
    for (int i = 0; i < DEPTH + 2; i++)
      step(1'b0, 32'h0, 1'b1, gen_word(), 1'b0, 1'b0);
    step(1'b0, 32'h0, 1'b0, 32'h0, 1'b0, 1'b1);

    for (int i = 0; i < 4000; i++)
      step(($urandom % 50) == 0, $urandom, ($urandom % 10) < 6, gen_word(),
           ($urandom % 16) == 0, ($urandom % 10) < 7);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule